// File: doc/BRIEF.md
# Extension Mode Gate with Counted Enable

This block sits beside the instruction decoder and decides, one decoded instruction at a time, whether that instruction may issue or must raise an illegal-instruction trap. The decision rests on a small mode register. Its low part holds one enable bit per extension class. Above that sits a two-bit binary selector that picks one of three further extension classes. Above the selector is a reserved pair of bits that must stay zero. The top four bits hold a countdown. Base instructions (class 0) always issue. An extension instruction issues only while its mode is active.

Software changes the mode register with a mode-write instruction. The write takes effect for the very next instruction. A non-zero countdown makes the written enables temporary. They last for that many issued instructions, then every enable and the selector clear by themselves. A branch or other PC change while the countdown is running traps instead of carrying the count across it. On trap entry the whole register, countdown included, is copied to a shadow and the live register clears, so the handler runs on the base set. Trap return copies the shadow back.

Top module: `ext_mode_gate`

## Requirements
- R1: After reset the mode register reads all zero: class 0 issues and every class 1 to 7 traps.
- R2: Class k, for k from 1 to 4, issues only when modeBits[k-1] is 1. Otherwise illegalTrap is raised for it.
- R3: Classes 5, 6 and 7 issue only when the selector modeBits[5:4] equals 1, 2 and 3 respectively. Otherwise they trap.
- R4: An issued mode write loads all 12 bits of instModeData, and the next instruction is judged against the new value.
- R5: A mode write with either reserved bit modeBits[7:6] set to 1 traps at any privilege, and the register keeps its value.
- R6: Bits 5:3 are privileged. A mode write with instKernel low that would change any of them traps, and the register keeps its value. A user write that leaves them unchanged issues.
- R7: After a write with countdown N (bits 11:8) non-zero, the next N issued instructions see the written modes. The Nth clears bits 5:0 and the countdown.
- R8: The countdown drops by one per issued non-write instruction only. Bubbles and trapped instructions leave it alone, and the writing instruction itself does not count.
- R9: An instruction with instPcChange set traps while the countdown is non-zero. With the countdown at zero it issues normally.
- R10: trapEnter copies the full register to a shadow and clears the live register. trapReturn (when trapEnter is low) copies the shadow back.
- R11: In a cycle with trapEnter or trapReturn, a valid instruction neither issues nor traps. If that instruction would have been the last of a countdown, the saved count is the value before any decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | A decoded instruction is presented this cycle |
| instClass | input | 3 | Extension class of the instruction, 0 = base |
| instPcChange | input | 1 | Instruction changes the PC non-sequentially |
| instModeWr | input | 1 | Instruction writes the mode register |
| instModeData | input | 12 | Value to write to the mode register |
| instKernel | input | 1 | Instruction runs at kernel privilege |
| trapEnter | input | 1 | Trap entry strobe |
| trapReturn | input | 1 | Trap return strobe |
| issueOk | output | 1 | Presented instruction may issue |
| illegalTrap | output | 1 | Presented instruction raises an illegal-instruction trap |
| modeBits | output | 12 | Current live mode register |

## Verification
The whole mode register drives modeBits directly, so any wrong enable, selector or count value is visible on the cycle after the edge that stored it. A wrong value also changes issueOk and illegalTrap for the very next instruction of an affected class. A shadow that was captured wrongly stays hidden until trap return, and then shows at once on modeBits. The sweeps therefore compare modeBits after every instruction, bubble and trap strobe. They also run each countdown length from 1 to 15 through to its expiry.

// File: rtl/mode_gate_pkg.sv
package mode_gate_pkg;
  localparam int UNARY_W = 4;
  localparam int FLAV_W  = 2;
  localparam int RSV_W   = 2;
  localparam int CNT_W   = 4;
  localparam int FLAV_LO = UNARY_W;
  localparam int RSV_LO  = FLAV_LO + FLAV_W;
  localparam int CNT_LO  = RSV_LO + RSV_W;
  localparam int REG_W   = CNT_LO + CNT_W;
  localparam int NUM_CLS = 1 + UNARY_W + (1 << FLAV_W) - 1;
  localparam int CLS_W   = $clog2(NUM_CLS);

  typedef struct packed {
    logic save;
    logic restore;
    logic write;
    logic tick;
  } gateStrobes_t;
endpackage

// File: rtl/mode_gate_ctrl.sv
module mode_gate_ctrl
  import mode_gate_pkg::*;
#(
  parameter logic [REG_W-1:0] PRIV_MASK = REG_W'(12'h038)
) (
  input  logic                instValid,
  input  logic [CLS_W-1:0]    instClass,
  input  logic                instPcChange,
  input  logic                instModeWr,
  input  logic [REG_W-1:0]    instModeData,
  input  logic                instKernel,
  input  logic                trapEnter,
  input  logic                trapReturn,
  input  logic [REG_W-1:0]    modeReg,
  output logic                issueOk,
  output logic                illegalTrap,
  output gateStrobes_t        strobes
);
  logic [FLAV_W-1:0] flavor;
  logic classOk, countLive, rsvBad, privBad, writeBad, pcBad, fault, trapCycle;

  assign flavor    = modeReg[FLAV_LO +: FLAV_W];
  assign countLive = modeReg[CNT_LO +: CNT_W] != '0;

  // Class admission: base always, unary region per bit, binary region by value.
  always_comb begin
    classOk = (instClass == '0);
    for (int k = 1; k <= UNARY_W; k++) begin
      if (instClass == CLS_W'(k)) classOk = modeReg[k-1];
    end
    for (int f = 1; f < (1 << FLAV_W); f++) begin
      if (instClass == CLS_W'(UNARY_W + f)) classOk = (flavor == FLAV_W'(f));
    end
  end

  assign rsvBad    = instModeData[RSV_LO +: RSV_W] != '0;
  assign privBad   = !instKernel && (((instModeData ^ modeReg) & PRIV_MASK) != '0);
  assign writeBad  = instModeWr && (rsvBad || privBad);
  assign pcBad     = instPcChange && countLive;
  assign fault     = !classOk || pcBad || writeBad;
  assign trapCycle = trapEnter || trapReturn;

  assign issueOk     = instValid && !trapCycle && !fault;
  assign illegalTrap = instValid && !trapCycle && fault;

  assign strobes.save    = trapEnter;
  assign strobes.restore = trapReturn && !trapEnter;
  assign strobes.write   = issueOk && instModeWr;
  assign strobes.tick    = issueOk && !instModeWr && countLive;
endmodule

// File: rtl/mode_gate_dp.sv
module mode_gate_dp
  import mode_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  gateStrobes_t     strobes,
  input  logic [REG_W-1:0] writeData,
  output logic [REG_W-1:0] modeReg
);
  logic [REG_W-1:0] liveReg, shadowReg;
  logic [CNT_W-1:0] curCount;
  logic             expiring;

  assign curCount = liveReg[CNT_LO +: CNT_W];
  assign expiring = strobes.tick && (curCount == CNT_W'(1));
  assign modeReg  = liveReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      liveReg   <= '0;
      shadowReg <= '0;
    end else if (strobes.save) begin
      shadowReg <= liveReg;
      liveReg   <= '0;
    end else if (strobes.restore) begin
      liveReg <= shadowReg;
    end else if (strobes.write) begin
      liveReg <= writeData;
    end else if (strobes.tick) begin
      liveReg[CNT_LO +: CNT_W] <= curCount - CNT_W'(1);
      if (expiring) liveReg[RSV_LO-1:0] <= '0;
    end
  end

  assert_save_R10: assert property (@(posedge clk) disable iff (rst)
    strobes.save |=> (shadowReg == $past(liveReg)) && (liveReg == '0));
  assert_restore_R10: assert property (@(posedge clk) disable iff (rst)
    strobes.restore |=> liveReg == $past(shadowReg));
  assert_expire_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (strobes.tick && curCount == CNT_W'(1)) |=> liveReg == '0);
  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (rst)
    liveReg[RSV_LO +: RSV_W] == '0);
endmodule

// File: rtl/ext_mode_gate.sv
module ext_mode_gate
  import mode_gate_pkg::*;
#(
  parameter logic [REG_W-1:0] PRIV_MASK = REG_W'(12'h038)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instValid,
  input  logic [CLS_W-1:0] instClass,
  input  logic             instPcChange,
  input  logic             instModeWr,
  input  logic [REG_W-1:0] instModeData,
  input  logic             instKernel,
  input  logic             trapEnter,
  input  logic             trapReturn,
  output logic             issueOk,
  output logic             illegalTrap,
  output logic [REG_W-1:0] modeBits
);
  gateStrobes_t strobes;
  logic [CNT_W-1:0] curCount;
  logic [UNARY_W-1:0] unarySel;

  mode_gate_ctrl #(.PRIV_MASK(PRIV_MASK)) u_ctrl (
    .instValid    (instValid),
    .instClass    (instClass),
    .instPcChange (instPcChange),
    .instModeWr   (instModeWr),
    .instModeData (instModeData),
    .instKernel   (instKernel),
    .trapEnter    (trapEnter),
    .trapReturn   (trapReturn),
    .modeReg      (modeBits),
    .issueOk      (issueOk),
    .illegalTrap  (illegalTrap),
    .strobes      (strobes)
  );

  mode_gate_dp u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .writeData (instModeData),
    .modeReg   (modeBits)
  );

  assign curCount = modeBits[CNT_LO +: CNT_W];

  always_comb begin
    unarySel = '0;
    for (int k = 1; k <= UNARY_W; k++) unarySel[k-1] = (instClass == CLS_W'(k));
  end

  assert_issue_unary_R2: assert property (@(posedge clk) disable iff (rst)
    (issueOk && unarySel != '0) |-> (unarySel & modeBits[UNARY_W-1:0]) != '0);
  assert_illegal_hold_R5: assert property (@(posedge clk) disable iff (rst)
    illegalTrap |=> modeBits == $past(modeBits));
  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
    (issueOk && !instModeWr && curCount > CNT_W'(1)) |=> curCount == $past(curCount) - CNT_W'(1));
  assert_bubble_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!instValid && !trapEnter && !trapReturn) |=> $stable(modeBits));
  assert_pc_change_R9: assert property (@(posedge clk) disable iff (rst)
    (issueOk && instPcChange) |-> curCount == '0);
  assert_trap_cycle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (trapEnter || trapReturn) |-> !issueOk && !illegalTrap);
endmodule

// File: tb/test_ext_mode_gate.sv
module test_ext_mode_gate;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instValid = 1'b0, instPcChange = 1'b0, instModeWr = 1'b0, instKernel = 1'b0;
  logic trapEnter = 1'b0, trapReturn = 1'b0;
  logic [2:0] instClass = '0;
  logic [11:0] instModeData = '0;
  logic issueOk, illegalTrap;
  logic [11:0] modeBits;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;
  logic [11:0] m = '0;      // bench model of the live register
  logic [11:0] shadow = '0; // bench model of the saved copy

  always #5 clk = ~clk;

  ext_mode_gate i_ext_mode_gate (
    .clk(clk), .rst(rst), .instValid(instValid), .instClass(instClass),
    .instPcChange(instPcChange), .instModeWr(instModeWr), .instModeData(instModeData),
    .instKernel(instKernel), .trapEnter(trapEnter), .trapReturn(trapReturn),
    .issueOk(issueOk), .illegalTrap(illegalTrap), .modeBits(modeBits)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit classAllowed(input logic [11:0] r, input int cls);
    if (cls == 0) return 1'b1;
    if (cls <= 4) return r[cls-1];
    return int'(r[5:4]) == cls - 4;
  endfunction

  task automatic exec(input int cls, input bit pc, input bit wr, input logic [11:0] data,
                      input bit kern, input string tag);
    bit bad;
    bit gotIss, gotIll;
    int cnt;
    cnt = int'(m[11:8]);
    bad = !classAllowed(m, cls) || (pc && cnt != 0) ||
          (wr && (data[7:6] != 2'b00 || (!kern && ((data ^ m) & 12'h038) != 12'h000)));
    @(negedge clk);
    instValid = 1'b1; instClass = 3'(cls); instPcChange = pc; instModeWr = wr;
    instModeData = data; instKernel = kern;
    #1;
    gotIss = issueOk; gotIll = illegalTrap;
    @(posedge clk); #1;
    instValid = 1'b0; instModeWr = 1'b0; instPcChange = 1'b0;
    if (!bad) begin
      if (wr) m = data;
      else if (cnt != 0) begin
        m[11:8] = 4'(cnt - 1);
        if (cnt == 1) m[5:0] = '0;
      end
    end
    check(gotIss == !bad, {tag, " issue"}, gotIss, !bad);
    check(gotIll == bad, {tag, " trap"}, gotIll, bad);
    check(modeBits == m, {tag, " mode"}, modeBits, m);
  endtask

  task automatic bubble(input string tag);
    @(negedge clk); #1;
    check(!issueOk && !illegalTrap, {tag, " bubble quiet"}, {issueOk, illegalTrap}, 0);
    @(posedge clk); #1;
    check(modeBits == m, {tag, " bubble mode"}, modeBits, m);
  endtask

  task automatic trapOp(input bit enter, input bit withInst, input string tag);
    @(negedge clk);
    trapEnter = enter; trapReturn = !enter;
    instValid = withInst; instClass = 3'd1; instModeWr = 1'b0; instPcChange = 1'b0;
    #1;
    check(!issueOk && !illegalTrap, {tag, " strobe cycle quiet"}, {issueOk, illegalTrap}, 0);
    @(posedge clk); #1;
    trapEnter = 1'b0; trapReturn = 1'b0; instValid = 1'b0;
    if (enter) begin shadow = m; m = '0; end
    else m = shadow;
    check(modeBits == m, {tag, " mode"}, modeBits, m);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state
    @(negedge clk);
    check(modeBits == 12'h000, "R1 reset mode", modeBits, 0);
    for (int c = 0; c < 8; c++) exec(c, 1'b0, 1'b0, '0, 1'b0, "R1 post-reset class");

    // R2 with R9 (pc change at count 0 allowed): every unary pattern times every class
    for (int u = 0; u < 16; u++) begin
      exec(0, 1'b0, 1'b1, 12'(u), 1'b1, "R4 kernel write");
      for (int c = 0; c < 8; c++) exec(c, c[0], 1'b0, '0, 1'b0, "R2 unary sweep R9");
    end

    // R3: every selector value times every class
    for (int f = 0; f < 4; f++) begin
      exec(0, 1'b0, 1'b1, 12'(f << 4), 1'b1, "R4 kernel write");
      for (int c = 0; c < 8; c++) exec(c, 1'b0, 1'b0, '0, 1'b0, "R3 selector sweep");
    end

    // R5 and R6: every low byte written from user level, from two start values
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 256; d++) begin
        exec(0, 1'b0, 1'b1, (s != 0) ? 12'h02A : 12'h000, 1'b1, "R4 kernel preset");
        exec(0, 1'b0, 1'b1, 12'(d), 1'b0, "R5 R6 user write");
      end
    end
    exec(0, 1'b0, 1'b1, 12'h0C0, 1'b1, "R5 kernel reserved write");
    exec(0, 1'b0, 1'b1, 12'h038, 1'b1, "R6 kernel privileged write");

    // R7, R8, R9: every countdown length
    for (int n = 1; n < 16; n++) begin
      bit kern;
      kern = n[0];
      exec(0, 1'b0, 1'b1, 12'((n << 8) | (kern ? 12'h011 : 12'h001)), kern, "R7 counted write");
      bubble("R8");
      exec(2, 1'b0, 1'b0, '0, 1'b0, "R8 trapped no tick");
      exec(1, 1'b1, 1'b0, '0, 1'b0, "R9 pc change during count");
      for (int k = 0; k < n; k++) begin
        exec(1, 1'b0, 1'b0, '0, 1'b0, "R7 counted issue");
        bubble("R8");
      end
      exec(1, 1'b0, 1'b0, '0, 1'b0, "R7 after expiry");
      exec(5, 1'b0, 1'b0, '0, 1'b0, "R7 selector after expiry");
      exec(1, 1'b1, 1'b0, '0, 1'b0, "R9 pc change after expiry");
    end

    // R10: save, run handler on base set, restore, finish the count
    exec(0, 1'b0, 1'b1, 12'h325, 1'b1, "R10 counted write");
    exec(1, 1'b0, 1'b0, '0, 1'b0, "R10 first issue");
    trapOp(1'b1, 1'b1, "R10 enter");
    exec(1, 1'b0, 1'b0, '0, 1'b0, "R10 handler base only");
    exec(0, 1'b0, 1'b0, '0, 1'b0, "R10 handler base issue");
    trapOp(1'b0, 1'b1, "R10 return");
    exec(6, 1'b0, 1'b0, '0, 1'b0, "R10 restored selector");
    exec(3, 1'b0, 1'b0, '0, 1'b0, "R10 restored unary last");
    exec(3, 1'b0, 1'b0, '0, 1'b0, "R10 expired after restore");

    // R11: trap entry when the presented instruction would end the count
    exec(0, 1'b0, 1'b1, 12'h102, 1'b0, "R11 user counted write");
    trapOp(1'b1, 1'b1, "R11 enter at last count");
    trapOp(1'b0, 1'b0, "R11 return");
    check(modeBits[11:8] == 4'd1, "R11 saved count pre-decrement", modeBits[11:8], 1);
    exec(2, 1'b0, 1'b0, '0, 1'b0, "R11 final counted issue");
    exec(2, 1'b0, 1'b0, '0, 1'b0, "R11 expired");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule